// File: doc/BRIEF.md
# Read-Triggered A/D Register Interface

This block is the host-side register logic of a small data-acquisition card on an 8-bit I/O bus. A 4-bit byte offset is decoded from a 16-byte window. A write-only control byte drives the analog channel select, the gain code, the pacer enable and the pacer interrupt enable. A status byte returns the end-of-conversion flag, two timer output levels and five digital input lines. The 12-bit conversion result is read back as a low byte and a high byte.

There is no separate start register. A conversion starts whenever the host reads the low result byte. The normal sequence is to read the high byte first and the low byte second, so one low-byte read finishes a sample and starts the next one. The converter is reached through a start pulse, a busy level and a 12-bit data bus. The busy level can change at any time relative to the bus clock, so it is passed through a synchroniser. A conversion completes on the falling edge of the synchronised busy level. At that edge the data is captured into a holding register and end-of-conversion is set.

Top module: `daq_adc_regs`

## Requirements
- R1: While reset is held and after it is released, the channel select, gain select, pacer enable, interrupt enable, start pulse and end-of-conversion flag (status bit 5) are all zero.
- R2: A write at offset 0x0 changes the outputs on the next clock. Data bits 3:0 drive the channel select, bits 5:4 the gain select, bit 6 the pacer enable and bit 7 the interrupt enable.
- R3: A read at offset 0x0 returns a status byte. Bit 7 is the timer-2 level, bit 6 the pacer level, bit 5 end-of-conversion and bits 4:0 the digital inputs.
- R4: A read at offset 0x8 produces a start pulse that is high for exactly the one clock after the read cycle. A read at any other offset produces no start pulse.
- R5: A start clears end-of-conversion. End-of-conversion stays clear while busy is high. It sets a few clocks after busy falls, once the synchroniser has passed the edge.
- R6: When a conversion completes, the data bus is captured. Offset 0x8 then returns result bits 7:0, and offset 0x9 returns result bits 11:8 in bits 3:0 with bits 7:4 reading zero.
- R7: A new start does not change the bytes read at offsets 0x8 and 0x9 until that conversion completes.
- R8: A busy falling edge with no conversion outstanding is ignored. The held result and end-of-conversion stay unchanged.
- R9: Writes to any offset other than 0x0 leave the control outputs unchanged. Reads at offsets other than 0x0, 0x8 and 0x9 return zero.
- R10: A low-byte read during a running conversion issues another start pulse and keeps end-of-conversion clear. The following busy fall completes the conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Byte offset within the window |
| busWrEn | input | 1 | Write strobe, one cycle per access |
| busWrData | input | 8 | Write data |
| busRdEn | input | 1 | Read strobe, one cycle per access |
| busRdData | output | 8 | Read data, valid in the read cycle |
| chanSel | output | 4 | Analog channel select |
| gainSel | output | 2 | Amplifier gain code |
| pacerEn | output | 1 | Pacer enable |
| pacerIrqEn | output | 1 | Pacer interrupt enable |
| timer2Lvl | input | 1 | Timer-2 output level |
| pacerLvl | input | 1 | Pacer output level |
| digIn | input | 5 | Digital input lines |
| adcStart | output | 1 | Conversion start pulse |
| adcBusy | input | 1 | Converter busy level, not synchronous to clk |
| adcData | input | 12 | Converter result bus |

## Verification
The bench uses the default 12-bit result and a two-stage synchroniser. At these sizes every control byte, every combination of the seven status inputs and a dense spread of result codes, including 0x000 and 0xFFF, can each be swept in full. The two-stage synchroniser keeps the busy-to-flag latency short and fixed. Because of that, the bench can check that the flag is still clear just after busy falls and set once the edge has passed through.

// File: rtl/daq_adc_regs_pkg.sv
package daq_adc_regs_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_LOW  = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_HIGH = 4'h9;
  localparam int CHAN_W = 4;
  localparam int GAIN_W = 2;
  localparam int DIN_W  = 5;

  typedef struct packed {
    logic loadCtrl;
    logic trigger;
    logic rdStatus;
    logic rdLow;
    logic rdHigh;
  } daqStrobes_t;
endpackage

// File: rtl/daq_adc_regs_ctrl.sv
module daq_adc_regs_ctrl
  import daq_adc_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output daqStrobes_t       strb,
  output logic              adcStart
);
  always_comb begin
    strb.loadCtrl = busWrEn && (busAddr == OFF_CTRL);
    strb.rdStatus = busRdEn && (busAddr == OFF_CTRL);
    strb.rdLow    = busRdEn && (busAddr == OFF_LOW);
    strb.rdHigh   = busRdEn && (busAddr == OFF_HIGH);
    strb.trigger  = strb.rdLow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) adcStart <= 1'b0;
    else       adcStart <= strb.trigger;
  end

  // R4: a start pulse is always preceded by a low-byte read on the bus
  assert_start_after_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcStart) |-> $past(busRdEn) && $past(busAddr) == OFF_LOW);
endmodule

// File: rtl/daq_adc_regs_datapath.sv
module daq_adc_regs_datapath
  import daq_adc_regs_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int SYNC_STAGES = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  daqStrobes_t       strb,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  output logic [CHAN_W-1:0] chanSel,
  output logic [GAIN_W-1:0] gainSel,
  output logic              pacerEn,
  output logic              pacerIrqEn,
  input  logic              timer2Lvl,
  input  logic              pacerLvl,
  input  logic [DIN_W-1:0]  digIn,
  input  logic              adcBusy,
  input  logic [RES_W-1:0]  adcData
);
  localparam int HI_W = RES_W - 8;

  logic [7:0]             ctrlReg;
  logic [SYNC_STAGES-1:0] busySync;
  logic                   busyPrev;
  logic                   busyFall;
  logic                   pending;
  logic                   eoc;
  logic                   capture;
  logic [RES_W-1:0]       resultHold;

  always_ff @(posedge clk) begin
    if (!rstN)              ctrlReg <= '0;
    else if (strb.loadCtrl) ctrlReg <= busWrData;
  end

  assign chanSel    = ctrlReg[CHAN_W-1:0];
  assign gainSel    = ctrlReg[CHAN_W+GAIN_W-1:CHAN_W];
  assign pacerEn    = ctrlReg[6];
  assign pacerIrqEn = ctrlReg[7];

  generate
    if (SYNC_STAGES > 1) begin : gSyncChain
      always_ff @(posedge clk) begin
        if (!rstN) busySync <= '0;
        else       busySync <= {busySync[SYNC_STAGES-2:0], adcBusy};
      end
    end else begin : gSyncSingle
      always_ff @(posedge clk) begin
        if (!rstN) busySync <= '0;
        else       busySync <= adcBusy;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) busyPrev <= 1'b0;
    else       busyPrev <= busySync[SYNC_STAGES-1];
  end

  assign busyFall = busyPrev && !busySync[SYNC_STAGES-1];
  assign capture  = busyFall && pending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending    <= 1'b0;
      eoc        <= 1'b0;
      resultHold <= '0;
    end else begin
      if (capture) resultHold <= adcData;
      if (strb.trigger) begin
        pending <= 1'b1;
        eoc     <= 1'b0;
      end else if (capture) begin
        pending <= 1'b0;
        eoc     <= 1'b1;
      end
    end
  end

  always_comb begin
    busRdData = 8'h00;
    if (strb.rdStatus)    busRdData = {timer2Lvl, pacerLvl, eoc, digIn};
    else if (strb.rdLow)  busRdData = resultHold[7:0];
    else if (strb.rdHigh) busRdData = {{(8-HI_W){1'b0}}, resultHold[RES_W-1:8]};
  end

  // R2: a decoded control write lands on the select outputs one clock later
  assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCtrl |=> {pacerIrqEn, pacerEn, gainSel, chanSel} == $past(busWrData));
  // R5: a trigger always leaves end-of-conversion clear
  assert_eoc_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.trigger |=> !eoc);
  // R5: the flag never shows while a conversion is outstanding
  assert_eoc_pending_R5: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> !eoc);
  // R8: a busy fall with nothing outstanding leaves the flag alone
  assert_stray_fall_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busyFall && !pending && !strb.trigger) |=> $stable(eoc) && $stable(resultHold));
endmodule

// File: rtl/daq_adc_regs.sv
module daq_adc_regs
  import daq_adc_regs_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int SYNC_STAGES = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrData,
  input  logic              busRdEn,
  output logic [7:0]        busRdData,
  output logic [CHAN_W-1:0] chanSel,
  output logic [GAIN_W-1:0] gainSel,
  output logic              pacerEn,
  output logic              pacerIrqEn,
  input  logic              timer2Lvl,
  input  logic              pacerLvl,
  input  logic [DIN_W-1:0]  digIn,
  output logic              adcStart,
  input  logic              adcBusy,
  input  logic [RES_W-1:0]  adcData
);
  daqStrobes_t strb;

  daq_adc_regs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .strb(strb), .adcStart(adcStart)
  );

  daq_adc_regs_datapath #(.RES_W(RES_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWrData(busWrData),
    .busRdData(busRdData), .chanSel(chanSel), .gainSel(gainSel),
    .pacerEn(pacerEn), .pacerIrqEn(pacerIrqEn), .timer2Lvl(timer2Lvl),
    .pacerLvl(pacerLvl), .digIn(digIn), .adcBusy(adcBusy), .adcData(adcData)
  );
endmodule

// File: tb/daq_adc_regs_tb.sv
module daq_adc_regs_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busRdData;
  logic [3:0]  chanSel;
  logic [1:0]  gainSel;
  logic        pacerEn, pacerIrqEn;
  logic        timer2Lvl = 1'b0, pacerLvl = 1'b0;
  logic [4:0]  digIn = '0;
  logic        adcStart;
  logic        adcBusy = 1'b0;
  logic [11:0] adcData = '0;

  int nChecks = 0;
  int nFail = 0;
  logic [7:0] rd;
  logic [11:0] held;

  always #10 clk = ~clk;

  daq_adc_regs u_dut (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    busWrEn = 1'b0;
  endtask

  // returns just after the negedge following the read; start pulse is visible then
  task automatic busRead(input logic [3:0] a, output logic [7:0] d);
    busAddr = a; busRdEn = 1'b1;
    #2 d = busRdData;
    @(posedge clk); @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic readStart(input string req);
    busRead(4'h8, rd);
    check(req, {15'd0, adcStart}, 16'd1);
    @(negedge clk);
    check(req, {15'd0, adcStart}, 16'd0);
  endtask

  task automatic runConv(input logic [11:0] v);
    adcBusy = 1'b1;
    repeat (3) @(negedge clk);
    adcData = v;
    adcBusy = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 during reset", {pacerIrqEn, pacerEn, gainSel, chanSel, adcStart}, 16'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ctrl after reset", {pacerIrqEn, pacerEn, gainSel, chanSel}, 16'd0);
    check("R1 start after reset", {15'd0, adcStart}, 16'd0);
    busRead(4'h0, rd);
    check("R1 eoc after reset", {15'd0, rd[5]}, 16'd0);

    // R2: sweep every control byte
    for (int v = 0; v < 256; v++) begin
      busWrite(4'h0, v[7:0]);
      check("R2 ctrl fields", {8'd0, pacerIrqEn, pacerEn, gainSel, chanSel},
            {8'd0, v[7], v[6], v[5:4], v[3:0]});
    end

    // R9: writes elsewhere ignored
    busWrite(4'h0, 8'hA5);
    for (int a = 1; a < 16; a++) begin
      busWrite(a[3:0], 8'h5A);
      check("R9 write ignored", {8'd0, pacerIrqEn, pacerEn, gainSel, chanSel}, 16'h00A5);
    end

    // R3: all status input combinations (eoc clear here)
    for (int s = 0; s < 128; s++) begin
      timer2Lvl = s[6]; pacerLvl = s[5]; digIn = s[4:0];
      busRead(4'h0, rd);
      check("R3 status", {8'd0, rd}, {8'd0, s[6], s[5], 1'b0, s[4:0]});
      check("R4 no start on status read", {15'd0, adcStart}, 16'd0);
    end
    timer2Lvl = 0; pacerLvl = 0; digIn = 0;

    // R9: reads at unused offsets return zero and do not start
    for (int a = 1; a < 16; a++) begin
      if (a == 8 || a == 9) continue;
      busRead(a[3:0], rd);
      check("R9 unused read", {8'd0, rd}, 16'd0);
      check("R4 no start on unused read", {15'd0, adcStart}, 16'd0);
    end

    // R5/R6: conversion sweep
    readStart("R4 first start");
    for (int k = 0; k <= 64; k++) begin
      logic [11:0] val;
      val = (k == 64) ? 12'hFFF : 12'(k * 63);
      busRead(4'h0, rd);
      check("R5 eoc clear after start", {15'd0, rd[5]}, 16'd0);
      adcBusy = 1'b1;
      repeat (3) @(negedge clk);
      busRead(4'h0, rd);
      check("R5 eoc clear while busy", {15'd0, rd[5]}, 16'd0);
      adcData = val;
      adcBusy = 1'b0;
      @(negedge clk);
      busRead(4'h0, rd);
      check("R5 eoc not yet through sync", {15'd0, rd[5]}, 16'd0);
      repeat (4) @(negedge clk);
      busRead(4'h0, rd);
      check("R5 eoc set", {15'd0, rd[5]}, 16'd1);
      busRead(4'h9, rd);
      check("R6 high byte", {8'd0, rd}, {12'd0, val[11:8]});
      check("R4 no start on high read", {15'd0, adcStart}, 16'd0);
      busRead(4'h8, rd);
      check("R6 low byte", {8'd0, rd}, {8'd0, val[7:0]});
      check("R4 start from low read", {15'd0, adcStart}, 16'd1);
      @(negedge clk);
      check("R4 start one clock", {15'd0, adcStart}, 16'd0);
    end
    // a conversion is now pending; complete it with 0x3C7
    runConv(12'h3C7);
    held = 12'h3C7;

    // R7: new trigger does not disturb held bytes until done
    readStart("R7 trigger");
    adcBusy = 1'b1; adcData = 12'h812;
    repeat (3) @(negedge clk);
    busRead(4'h9, rd);
    check("R7 high held", {8'd0, rd}, {12'd0, held[11:8]});
    // R10: re-arm during conversion
    readStart("R10 rearm start");
    busRead(4'h0, rd);
    check("R10 eoc clear after rearm", {15'd0, rd[5]}, 16'd0);
    adcBusy = 1'b0;
    repeat (6) @(negedge clk);
    busRead(4'h0, rd);
    check("R10 eoc set after fall", {15'd0, rd[5]}, 16'd1);
    busRead(4'h9, rd);
    check("R10 high new", {8'd0, rd}, 16'h0008);

    // R8: stray busy fall with nothing outstanding
    adcBusy = 1'b1;
    repeat (3) @(negedge clk);
    adcData = 12'h0FF;
    adcBusy = 1'b0;
    repeat (6) @(negedge clk);
    busRead(4'h0, rd);
    check("R8 eoc unchanged", {15'd0, rd[5]}, 16'd1);
    busRead(4'h9, rd);
    check("R8 high unchanged", {8'd0, rd}, 16'h0008);
    busRead(4'h8, rd);
    check("R8 low unchanged", {8'd0, rd}, 16'h0012);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule